// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state changes a processor core makes when it takes an exception, and it supplies the address the core fetches from next. The core presents a single-cycle request with the following fields:

- the faulting program counter, and whether that instruction sat in a branch delay slot;
- a coprocessor number;
- either a direct cause code, or, for faults raised by address translation, the translation error kind and whether the access was a store;
- the faulting virtual address.

The block keeps the exception-level flag, the saved exception PC and the cause fields. For translation faults it also keeps the captured address fields: the full bad address, the short and long page-number fields, and the region bits.

The next fetch address is chosen from three vectors under a common base. General exceptions, nested translation faults and invalid-entry faults go to offset 0x180. A translation miss taken while the exception level is clear goes to a refill vector. That vector is at offset 0x080 when the faulting address uses 64-bit addressing and at offset 0x000 when it does not. Whether an address uses 64-bit addressing depends on its two top bits and on three status enables that the core supplies.

The bootstrap-vector mode is not handled here. When its status bit is set, the block raises an error pulse and does not redirect.

Top module: `exc_entry_unit`

## Requirements
- R1: On a request taken while the exception level is clear, the following hold one cycle later. The exception level is 1 and the branch-delay bit equals the delay flag. The saved PC equals the request PC, or the request PC minus 4 when the delay flag is 1.
- R2: On a request taken while the exception level is already 1, the saved PC and the branch-delay bit keep their values. The cause code and the coprocessor field still take the new request's values.
- R3: For translation requests the cause code comes from the error kind and the store flag. Error kind encoding: 0 miss, 1 invalid, 2 modification, 3 disallowed address. Miss and invalid give 2 for a load and 3 for a store. Modification gives 1. Disallowed address gives 4 for a load and 5 for a store. For other requests the cause code is the request code unchanged.
- R4: A request whose cause code is not 2 or 3 redirects to 0xFFFFFFFF80000180.
- R5: A request with cause code 2 or 3 redirects to 0xFFFFFFFF80000180 when the exception level was already 1 or the error kind is invalid. Otherwise it redirects to 0xFFFFFFFF80000080 for a 64-bit faulting address and to 0xFFFFFFFF80000000 for a 32-bit one.
- R6: A faulting address uses 64-bit addressing when bits 63:62 are 00 with the user enable set, 01 with the supervisor enable set, or 11 with the kernel enable set. The value 10 never does.
- R7: A translation request captures the following fields:
  - the bad address receives the full address;
  - the short page field receives bits 31:13;
  - both long page fields receive bits 39:13;
  - both region fields receive bits 63:62.

  Non-translation requests leave all of these fields unchanged.
- R8: When the bootstrap-vector bit is 1 on a request, the error output pulses for one cycle and no redirect is issued. The exception state is still updated.
- R9: After reset the following hold: the exception level is 0, the redirect and error outputs are 0, the saved PC and the bad address are all ones, and the remaining fields are 0.
- R10: The redirect valid output is a one-cycle pulse in the cycle after the request, and all state reflects the request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Exception request, one cycle |
| req_xlat_i | input | 1 | Request raised by address translation |
| req_code_i | input | 5 | Cause code for non-translation requests |
| req_cop_i | input | 2 | Coprocessor number |
| req_pc_i | input | 64 | Faulting PC |
| req_delay_i | input | 1 | Faulting instruction is in a delay slot |
| req_vaddr_i | input | 64 | Faulting virtual address |
| xlat_err_i | input | 2 | Translation error kind |
| xlat_store_i | input | 1 | Faulting access is a store |
| st_ux_i | input | 1 | User 64-bit addressing enable |
| st_sx_i | input | 1 | Supervisor 64-bit addressing enable |
| st_kx_i | input | 1 | Kernel 64-bit addressing enable |
| st_bev_i | input | 1 | Bootstrap-vector mode bit |
| redirect_valid_o | output | 1 | Next fetch PC is valid |
| redirect_pc_o | output | 64 | Next fetch PC |
| bev_err_o | output | 1 | Request taken in bootstrap-vector mode |
| exl_o | output | 1 | Exception level flag |
| epc_o | output | 64 | Saved exception PC |
| cause_bd_o | output | 1 | Branch-delay bit |
| cause_code_o | output | 5 | Exception cause code |
| cause_ce_o | output | 2 | Coprocessor error field |
| badvaddr_o | output | 64 | Bad virtual address |
| ctx_vpn_o | output | 19 | Short page number field |
| xctx_vpn_o | output | 27 | Long page number field (extended context) |
| xctx_region_o | output | 2 | Region field (extended context) |
| ehi_vpn_o | output | 27 | Long page number field (entry high) |
| ehi_region_o | output | 2 | Region field (entry high) |

## Verification
Some properties are checked on every cycle:

- the exception level is set after any request;
- a nested request leaves the saved PC and the delay bit unchanged;
- the saved PC on a first entry follows the request PC, with the delay-slot adjustment;
- no redirect accompanies the bootstrap-vector error;
- every redirect lands on one of the three legal vectors;
- a non-translation request leaves the captured address fields unchanged.

Other behaviour can only be shown by the bench scenarios:

- the cause mapping for each error kind and access type;
- which vector is chosen for each combination of region bits and status enables;
- the exact bit slices captured from a faulting address.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    XERR_MISS    = 2'd0,
    XERR_INVALID = 2'd1,
    XERR_MODIFY  = 2'd2,
    XERR_BADADDR = 2'd3
  } xlat_err_e;

  localparam logic [4:0] CODE_INT   = 5'd0;
  localparam logic [4:0] CODE_MOD   = 5'd1;
  localparam logic [4:0] CODE_TLBL  = 5'd2;
  localparam logic [4:0] CODE_TLBS  = 5'd3;
  localparam logic [4:0] CODE_ADEL  = 5'd4;
  localparam logic [4:0] CODE_ADES  = 5'd5;

  localparam logic [11:0] OFS_GENERAL = 12'h180;
  localparam logic [11:0] OFS_XREFILL = 12'h080;
  localparam logic [11:0] OFS_REFILL  = 12'h000;

  // Translation error kind plus access direction to cause code.
  function automatic logic [4:0] xlat_cause(input xlat_err_e err, input logic is_store);
    logic [4:0] c;
    unique case (err)
      XERR_MISS, XERR_INVALID: c = is_store ? CODE_TLBS : CODE_TLBL;
      XERR_MODIFY:             c = CODE_MOD;
      default:                 c = is_store ? CODE_ADES : CODE_ADEL;
    endcase
    return c;
  endfunction

  // Whether an address region uses 64-bit addressing under the given enables.
  function automatic logic region_is_wide(input logic [1:0] region,
                                          input logic ux, input logic sx, input logic kx);
    logic w;
    unique case (region)
      2'b00:   w = ux;
      2'b01:   w = sx;
      2'b11:   w = kx;
      default: w = 1'b0;
    endcase
    return w;
  endfunction

  // Offset of the vector within the exception base.
  function automatic logic [11:0] vector_offset(input logic [4:0] code, input logic old_exl,
                                                input xlat_err_e err, input logic wide);
    logic [11:0] o;
    if ((code == CODE_TLBL || code == CODE_TLBS) && !old_exl && err != XERR_INVALID)
      o = wide ? OFS_XREFILL : OFS_REFILL;
    else
      o = OFS_GENERAL;
    return o;
  endfunction

endpackage

// File: rtl/exc_cause_map.sv
module exc_cause_map
  import exc_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              is_xlat_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        err_i,
  input  logic              store_i,
  output logic [CODE_W-1:0] code_o
);
  logic [4:0] xlat_code;

  always_comb begin
    xlat_code = xlat_cause(xlat_err_e'(err_i), store_i);
    code_o    = is_xlat_i ? CODE_W'(xlat_code) : code_i;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int          ADDR_W   = 64,
  parameter int          CODE_W   = 5,
  parameter logic [63:0] VEC_BASE = 64'hFFFF_FFFF_8000_0000
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              old_exl_i,
  input  logic [1:0]        err_i,
  input  logic [1:0]        region_i,
  input  logic              ux_i,
  input  logic              sx_i,
  input  logic              kx_i,
  output logic              wide_o,
  output logic              refill_o,
  output logic [ADDR_W-1:0] vec_pc_o
);
  logic [11:0] ofs;

  always_comb begin
    wide_o   = region_is_wide(region_i, ux_i, sx_i, kx_i);
    ofs      = vector_offset(5'(code_i), old_exl_i, xlat_err_e'(err_i), wide_o);
    refill_o = (ofs != OFS_GENERAL);
    vec_pc_o = ADDR_W'(VEC_BASE) + ADDR_W'(ofs);
  end

  // R4: only TLB load/store codes may leave the general vector
  always_comb begin
    if (refill_o) begin
      a_refill_code_r4: assert (code_i == CODE_W'(CODE_TLBL) || code_i == CODE_W'(CODE_TLBS));
    end
  end
endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture #(
  parameter int ADDR_W     = 64,
  parameter int VPN_LSB    = 13,
  parameter int CTX_VPN_W  = 19,
  parameter int XCTX_VPN_W = 27
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_en_i,
  input  logic [ADDR_W-1:0]     vaddr_i,
  output logic [ADDR_W-1:0]     badvaddr_o,
  output logic [CTX_VPN_W-1:0]  ctx_vpn_o,
  output logic [XCTX_VPN_W-1:0] xctx_vpn_o,
  output logic [1:0]            xctx_region_o,
  output logic [XCTX_VPN_W-1:0] ehi_vpn_o,
  output logic [1:0]            ehi_region_o
);
  localparam int REGION_LSB = ADDR_W - 2;

  logic [1:0] region_w;
  assign region_w = vaddr_i[REGION_LSB +: 2];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      badvaddr_o    <= '1;
      ctx_vpn_o     <= '0;
      xctx_vpn_o    <= '0;
      xctx_region_o <= '0;
      ehi_vpn_o     <= '0;
      ehi_region_o  <= '0;
    end else if (cap_en_i) begin
      badvaddr_o    <= vaddr_i;
      ctx_vpn_o     <= vaddr_i[VPN_LSB +: CTX_VPN_W];
      xctx_vpn_o    <= vaddr_i[VPN_LSB +: XCTX_VPN_W];
      xctx_region_o <= region_w;
      ehi_vpn_o     <= vaddr_i[VPN_LSB +: XCTX_VPN_W];
      ehi_region_o  <= region_w;
    end
  end

  p_hold_fields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(badvaddr_o) && $stable(xctx_vpn_o) && $stable(ehi_vpn_o)
                  && $stable(ctx_vpn_o));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          CODE_W     = 5,
  parameter int          CE_W       = 2,
  parameter int          VPN_LSB    = 13,
  parameter int          CTX_VPN_W  = 19,
  parameter int          XCTX_VPN_W = 27,
  parameter logic [63:0] VEC_BASE   = 64'hFFFF_FFFF_8000_0000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_xlat_i,
  input  logic [CODE_W-1:0]     req_code_i,
  input  logic [CE_W-1:0]       req_cop_i,
  input  logic [ADDR_W-1:0]     req_pc_i,
  input  logic                  req_delay_i,
  input  logic [ADDR_W-1:0]     req_vaddr_i,
  input  logic [1:0]            xlat_err_i,
  input  logic                  xlat_store_i,
  input  logic                  st_ux_i,
  input  logic                  st_sx_i,
  input  logic                  st_kx_i,
  input  logic                  st_bev_i,
  output logic                  redirect_valid_o,
  output logic [ADDR_W-1:0]     redirect_pc_o,
  output logic                  bev_err_o,
  output logic                  exl_o,
  output logic [ADDR_W-1:0]     epc_o,
  output logic                  cause_bd_o,
  output logic [CODE_W-1:0]     cause_code_o,
  output logic [CE_W-1:0]       cause_ce_o,
  output logic [ADDR_W-1:0]     badvaddr_o,
  output logic [CTX_VPN_W-1:0]  ctx_vpn_o,
  output logic [XCTX_VPN_W-1:0] xctx_vpn_o,
  output logic [1:0]            xctx_region_o,
  output logic [XCTX_VPN_W-1:0] ehi_vpn_o,
  output logic [1:0]            ehi_region_o
);
  localparam int          REGION_LSB = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] SLOT_BYTES = ADDR_W'(4);

  // Named internal events
  logic              first_entry_w;
  logic              nested_entry_w;
  logic              capture_en_w;
  logic [CODE_W-1:0] code_w;
  logic [ADDR_W-1:0] vec_pc_w;
  logic [ADDR_W-1:0] epc_next_w;
  logic              wide_w;
  logic              refill_w;

  assign first_entry_w  = req_valid_i & ~exl_o;
  assign nested_entry_w = req_valid_i &  exl_o;
  assign capture_en_w   = req_valid_i &  req_xlat_i;
  assign epc_next_w     = req_delay_i ? (req_pc_i - SLOT_BYTES) : req_pc_i;

  exc_cause_map #(.CODE_W(CODE_W)) u_cause (
    .is_xlat_i (req_xlat_i),
    .code_i    (req_code_i),
    .err_i     (xlat_err_i),
    .store_i   (xlat_store_i),
    .code_o    (code_w)
  );

  exc_vector_sel #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .VEC_BASE(VEC_BASE)) u_vec (
    .code_i    (code_w),
    .old_exl_i (exl_o),
    .err_i     (xlat_err_i),
    .region_i  (req_vaddr_i[REGION_LSB +: 2]),
    .ux_i      (st_ux_i),
    .sx_i      (st_sx_i),
    .kx_i      (st_kx_i),
    .wide_o    (wide_w),
    .refill_o  (refill_w),
    .vec_pc_o  (vec_pc_w)
  );

  exc_addr_capture #(
    .ADDR_W(ADDR_W), .VPN_LSB(VPN_LSB), .CTX_VPN_W(CTX_VPN_W), .XCTX_VPN_W(XCTX_VPN_W)
  ) u_cap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cap_en_i      (capture_en_w),
    .vaddr_i       (req_vaddr_i),
    .badvaddr_o    (badvaddr_o),
    .ctx_vpn_o     (ctx_vpn_o),
    .xctx_vpn_o    (xctx_vpn_o),
    .xctx_region_o (xctx_region_o),
    .ehi_vpn_o     (ehi_vpn_o),
    .ehi_region_o  (ehi_region_o)
  );

  // Exception level, saved PC and delay bit: only a first entry writes them.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      exl_o      <= 1'b0;
      epc_o      <= '1;
      cause_bd_o <= 1'b0;
    end else if (first_entry_w) begin
      exl_o      <= 1'b1;
      epc_o      <= epc_next_w;
      cause_bd_o <= req_delay_i;
    end
  end

  // Cause code and coprocessor field: every request writes them.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cause_code_o <= '0;
      cause_ce_o   <= '0;
    end else if (req_valid_i) begin
      cause_code_o <= code_w;
      cause_ce_o   <= req_cop_i;
    end
  end

  // Redirect and bootstrap-mode error pulses.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      bev_err_o        <= 1'b0;
    end else begin
      redirect_valid_o <= req_valid_i & ~st_bev_i;
      bev_err_o        <= req_valid_i &  st_bev_i;
      if (req_valid_i && !st_bev_i) redirect_pc_o <= vec_pc_w;
    end
  end

  // ---------------- assertions ----------------
  p_exl_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> exl_o);

  p_epc_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_entry_w |=> epc_o == ($past(req_delay_i) ? $past(req_pc_i) - SLOT_BYTES
                                                   : $past(req_pc_i)));

  p_nested_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nested_entry_w |=> $stable(epc_o) && $stable(cause_bd_o));

  p_vector_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> (redirect_pc_o == ADDR_W'(VEC_BASE) + ADDR_W'(12'h180) ||
                          redirect_pc_o == ADDR_W'(VEC_BASE) + ADDR_W'(12'h080) ||
                          redirect_pc_o == ADDR_W'(VEC_BASE)));

  p_refill_needs_clear_exl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && refill_w) |-> !exl_o);

  p_bev_no_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bev_err_o && redirect_valid_o));

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !redirect_valid_o && !bev_err_o);

  p_wide_region_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_vaddr_i[REGION_LSB +: 2] == 2'b10) |-> !wide_w);
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_xlat = 0, req_delay = 0, xstore = 0;
  logic [4:0] req_code = 0;
  logic [1:0] req_cop = 0, xerr = 0;
  logic [63:0] req_pc = 0, req_vaddr = 0;
  logic ux = 0, sx = 0, kx = 0, bev = 0;
  logic rv, bev_err, exl, bd;
  logic [63:0] rpc, epc, bad;
  logic [4:0] code;
  logic [1:0] ce, xreg, ereg;
  logic [18:0] cvpn;
  logic [26:0] xvpn, evpn;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [63:0] V180 = 64'hFFFF_FFFF_8000_0180;
  localparam logic [63:0] V080 = 64'hFFFF_FFFF_8000_0080;
  localparam logic [63:0] V000 = 64'hFFFF_FFFF_8000_0000;

  always #2 clk = ~clk;

  exc_entry_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_xlat_i(req_xlat),
    .req_code_i(req_code), .req_cop_i(req_cop), .req_pc_i(req_pc), .req_delay_i(req_delay),
    .req_vaddr_i(req_vaddr), .xlat_err_i(xerr), .xlat_store_i(xstore),
    .st_ux_i(ux), .st_sx_i(sx), .st_kx_i(kx), .st_bev_i(bev),
    .redirect_valid_o(rv), .redirect_pc_o(rpc), .bev_err_o(bev_err), .exl_o(exl),
    .epc_o(epc), .cause_bd_o(bd), .cause_code_o(code), .cause_ce_o(ce),
    .badvaddr_o(bad), .ctx_vpn_o(cvpn), .xctx_vpn_o(xvpn), .xctx_region_o(xreg),
    .ehi_vpn_o(evpn), .ehi_region_o(ereg)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; bev = 0; ux = 0; sx = 0; kx = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // Drive one request; return at the negedge after the capturing edge.
  task automatic send(input logic xl, input logic [4:0] c, input logic [1:0] cop,
                      input logic [63:0] pc, input logic dly, input logic [63:0] va,
                      input logic [1:0] err, input logic st);
    @(negedge clk);
    req_valid = 1; req_xlat = xl; req_code = c; req_cop = cop; req_pc = pc;
    req_delay = dly; req_vaddr = va; xerr = err; xstore = st;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 exl", 64'(exl), 0);
    chk("R9 redirect_valid", 64'(rv), 0);
    chk("R9 bev_err", 64'(bev_err), 0);
    chk("R9 epc", epc, '1);
    chk("R9 badvaddr", bad, '1);
    chk("R9 code", 64'(code), 0);
    chk("R9 ctx", 64'(cvpn), 0);
  endtask

  task automatic t_first_entry();
    do_reset();
    send(0, 5'd8, 2'd0, 64'hFFFF_FFFF_8000_1000, 0, 64'h55, 0, 0);
    chk("R1 exl", 64'(exl), 1);
    chk("R1 epc", epc, 64'hFFFF_FFFF_8000_1000);
    chk("R1 bd", 64'(bd), 0);
    chk("R3 general code", 64'(code), 8);
    chk("R10 redirect_valid", 64'(rv), 1);
    chk("R4 vector", rpc, V180);
    chk("R7 no capture on general", bad, '1);
    @(negedge clk);
    chk("R10 pulse ends", 64'(rv), 0);
  endtask

  task automatic t_delay_and_nested();
    do_reset();
    send(0, 5'd12, 2'd0, 64'hFFFF_FFFF_8000_2004, 1, 0, 0, 0);
    chk("R1 delay epc", epc, 64'hFFFF_FFFF_8000_2000);
    chk("R1 delay bd", 64'(bd), 1);
    send(0, 5'd11, 2'd1, 64'hFFFF_FFFF_8000_3000, 0, 0, 0, 0);
    chk("R2 nested epc kept", epc, 64'hFFFF_FFFF_8000_2000);
    chk("R2 nested bd kept", 64'(bd), 1);
    chk("R2 nested code", 64'(code), 11);
    chk("R2 nested ce", 64'(ce), 1);
    // nested miss goes to general vector
    send(1, 0, 0, 64'h100, 0, 64'h0000_0000_0040_0000, 2'd0, 0);
    chk("R5 nested miss vector", rpc, V180);
    chk("R3 miss load code", 64'(code), 2);
  endtask

  task automatic t_refill32();
    logic [63:0] va;
    va = 64'h0000_0000_1234_6ABC;
    do_reset();
    send(1, 0, 0, 64'h400, 0, va, 2'd0, 0);
    chk("R5 refill32 vector", rpc, V000);
    chk("R3 miss load", 64'(code), 2);
    chk("R7 badvaddr", bad, va);
    chk("R7 ctx", 64'(cvpn), 64'((va >> 13) & 64'h7FFFF));
    chk("R7 xctx", 64'(xvpn), 64'((va >> 13) & 64'h7FF_FFFF));
    chk("R7 ehi", 64'(evpn), 64'((va >> 13) & 64'h7FF_FFFF));
  endtask

  task automatic t_refill64();
    logic [63:0] va;
    va = 64'h4000_00AB_CDEF_2000;
    do_reset();
    sx = 1;
    send(1, 0, 0, 64'h400, 0, va, 2'd0, 1);
    chk("R6 region01 sx wide vector", rpc, V080);
    chk("R3 miss store", 64'(code), 3);
    chk("R7 xctx region", 64'(xreg), 1);
    chk("R7 ehi region", 64'(ereg), 1);
    chk("R7 xctx vpn", 64'(xvpn), 64'((va >> 13) & 64'h7FF_FFFF));
  endtask

  task automatic t_regions();
    do_reset();
    ux = 1; sx = 1; kx = 1;
    send(1, 0, 0, 0, 0, 64'h8000_0000_0000_0000, 2'd0, 0);
    chk("R6 region10 never wide", rpc, V000);
    chk("R7 region10", 64'(ereg), 2);
    do_reset();
    kx = 1;
    send(1, 0, 0, 0, 0, 64'hC000_0000_0000_0000, 2'd0, 0);
    chk("R6 region11 kx", rpc, V080);
    do_reset();
    sx = 1; kx = 1;
    send(1, 0, 0, 0, 0, 64'h0000_0001_0000_0000, 2'd0, 0);
    chk("R6 region00 ux clear", rpc, V000);
  endtask

  task automatic t_err_kinds();
    do_reset();
    send(1, 0, 0, 0, 0, 64'h2000, 2'd1, 1);
    chk("R5 invalid vector", rpc, V180);
    chk("R3 invalid store", 64'(code), 3);
    do_reset();
    send(1, 0, 0, 0, 0, 64'h2000, 2'd2, 1);
    chk("R3 modification", 64'(code), 1);
    chk("R4 modification vector", rpc, V180);
    do_reset();
    send(1, 0, 0, 0, 0, 64'h2000, 2'd3, 0);
    chk("R3 badaddr load", 64'(code), 4);
    do_reset();
    send(1, 0, 0, 0, 0, 64'h2000, 2'd3, 1);
    chk("R3 badaddr store", 64'(code), 5);
    chk("R4 badaddr vector", rpc, V180);
  endtask

  task automatic t_bev();
    do_reset();
    bev = 1;
    send(0, 5'd9, 0, 64'h800, 0, 0, 0, 0);
    chk("R8 bev error", 64'(bev_err), 1);
    chk("R8 no redirect", 64'(rv), 0);
    chk("R8 state updated", 64'(exl), 1);
    @(negedge clk);
    chk("R8 error pulse", 64'(bev_err), 0);
    bev = 0;
  endtask

  initial begin
    t_reset();
    t_first_entry();
    t_delay_and_nested();
    t_refill32();
    t_refill64();
    t_regions();
    t_err_kinds();
    t_bev();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule